// File: doc/BRIEF.md
# RISC Subset Decode-Execute Unit

This block takes one 32-bit instruction word per valid strobe and handles it from decode to write-back. It splits the word into fixed fields and reads two operands from an internal register file of 32 entries, each 32 bits wide. It then runs one of six arithmetic or compare operations and writes the destination entry. The supported operations are register-register add, subtract and signed set-less-than, plus add-immediate, signed set-less-than-immediate and load-upper-immediate.

A small state machine drives the outputs one clock after each strobe. It has four states:
- `S_IDLE`: no instruction was presented.
- `S_WRITE`: a legal instruction wrote a nonzero destination, and the write-back strobe is high.
- `S_SKIP`: a legal instruction named destination 0, so its result was dropped.
- `S_TRAP`: the word was not in the supported set, and the illegal flag is high.

On each clock edge, the next state is picked from the strobe and the decode result. It does not depend on the current state:
- `S_IDLE` is entered when the strobe is low.
- `S_TRAP` is entered when the word is unsupported.
- `S_SKIP` is entered when a legal instruction targets entry 0.
- `S_WRITE` is entered for every other legal instruction.

The register file is written on the same edge that moves the state, so an instruction issued in the next cycle already reads the new value. Register contents are observed through the normal interface. An add of a register with entry 0 shows its value on the write-back port.

Top module: `rsx_exec_unit`

## Requirements
- R1: After reset, `wb_en` and `illegal` are 0 and every register file entry reads as 0.
- R2: An R-type word (opcode bits [31:26] = 0, funct bits [5:0] = 32) writes rs+rt into rd, wrapping modulo 2^32. The fields are rs at [25:21], rt at [20:16] and rd at [15:11]. For example, word 0x02288020 adds entries 17 and 8 into entry 16.
- R3: An R-type word with funct 34 writes rs-rt into rd, wrapping modulo 2^32. Word 0x01309822 subtracts entry 16 from entry 9 into entry 19.
- R4: An R-type word with funct 42 writes 1 into rd when rs is less than rt as signed two's-complement values, and 0 otherwise.
- R5: Opcode 8 writes rs plus the sign-extended 16-bit immediate (bits [15:0]) into rt, wrapping modulo 2^32.
- R6: Opcode 10 writes 1 into rt when rs is signed-less-than the sign-extended immediate, and 0 otherwise.
- R7: Opcode 15 writes the immediate into bits [31:16] of rt, with bits [15:0] zero.
- R8: Entry 0 always reads as 0. A legal instruction whose destination is 0 leaves `wb_en` and `illegal` low and changes nothing.
- R9: Any other opcode, or opcode 0 with any other funct, raises `illegal` for one cycle with `wb_en` low, and leaves the register file unchanged.
- R10: Outputs for a strobed word appear in the cycle after the strobe. An instruction strobed in the next cycle sees the write. A cycle with no strobe is followed by `wb_en` and `illegal` both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | Strobe: `instr_word` holds an instruction this cycle |
| instr_word | input | 32 | Instruction word |
| wb_en | output | 1 | A register was written by the previous strobed word |
| wb_idx | output | 5 | Destination index of that write |
| wb_data | output | 32 | Value written |
| illegal | output | 1 | The previous strobed word was unsupported |

## Verification
The bench goes after these corner cases:
- Negative immediates: a design that zero-extends them returns values near 65536 instead of small negatives.
- Signed compares across the sign boundary: an unsigned compare ranks -1 above 1.
- Sums that overflow 32 bits.
- Load-upper results whose low half must be zero.
- Writes aimed at entry 0: if they land, later reads of entry 0 become nonzero.
- Unsupported opcodes and funct codes: a faulty decoder either writes a result or fails to raise the flag, and a later read-back of the targeted entry exposes the write.
- Back-to-back dependent instructions: if the register file updates late, the second instruction reads a stale operand.

// File: rtl/rsx_pkg.sv
package rsx_pkg;
    localparam int INSN_W    = 32;
    localparam int REG_IDX_W = 5;
    localparam int IMM_W     = 16;
    localparam int OPC_W     = 6;
    localparam int FUNCT_W   = 6;

    localparam logic [OPC_W-1:0]   OPC_RTYPE = 6'd0;
    localparam logic [OPC_W-1:0]   OPC_ADDI  = 6'd8;
    localparam logic [OPC_W-1:0]   OPC_SLTI  = 6'd10;
    localparam logic [OPC_W-1:0]   OPC_LUI   = 6'd15;
    localparam logic [FUNCT_W-1:0] FN_ADD    = 6'd32;
    localparam logic [FUNCT_W-1:0] FN_SUB    = 6'd34;
    localparam logic [FUNCT_W-1:0] FN_SLT    = 6'd42;

    typedef enum logic [1:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_SLT,
        ALU_LUI
    } alu_op_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_WRITE,
        S_SKIP,
        S_TRAP
    } exec_state_e;

    typedef struct packed {
        logic                 legal;
        alu_op_e              op;
        logic                 use_imm;
        logic [REG_IDX_W-1:0] src_a;
        logic [REG_IDX_W-1:0] src_b;
        logic [REG_IDX_W-1:0] dst;
        logic [IMM_W-1:0]     imm;
    } decoded_t;
endpackage

// File: rtl/rsx_decoder.sv
module rsx_decoder
    import rsx_pkg::*;
(
    input  logic [INSN_W-1:0] instr_word,
    output decoded_t          dec
);
    logic [OPC_W-1:0]   opc;
    logic [FUNCT_W-1:0] fn;

    assign opc = instr_word[31:26];
    assign fn  = instr_word[5:0];

    always_comb begin
        dec.legal   = 1'b0;
        dec.op      = ALU_ADD;
        dec.use_imm = 1'b0;
        dec.src_a   = instr_word[25:21];
        dec.src_b   = instr_word[20:16];
        dec.dst     = instr_word[15:11];
        dec.imm     = instr_word[15:0];
        unique case (opc)
            OPC_RTYPE: begin
                unique case (fn)
                    FN_ADD:  begin dec.legal = 1'b1; dec.op = ALU_ADD; end
                    FN_SUB:  begin dec.legal = 1'b1; dec.op = ALU_SUB; end
                    FN_SLT:  begin dec.legal = 1'b1; dec.op = ALU_SLT; end
                    default: dec.legal = 1'b0;
                endcase
            end
            OPC_ADDI: begin
                dec.legal   = 1'b1;
                dec.op      = ALU_ADD;
                dec.use_imm = 1'b1;
                dec.dst     = instr_word[20:16];
            end
            OPC_SLTI: begin
                dec.legal   = 1'b1;
                dec.op      = ALU_SLT;
                dec.use_imm = 1'b1;
                dec.dst     = instr_word[20:16];
            end
            OPC_LUI: begin
                dec.legal   = 1'b1;
                dec.op      = ALU_LUI;
                dec.use_imm = 1'b1;
                dec.dst     = instr_word[20:16];
            end
            default: dec.legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/rsx_regfile.sv
module rsx_regfile #(
    parameter  int XLEN  = 32,
    parameter  int DEPTH = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_a_idx,
    output logic [XLEN-1:0]  rd_a_data,
    input  logic [IDX_W-1:0] rd_b_idx,
    output logic [XLEN-1:0]  rd_b_data,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [XLEN-1:0]  wr_data
);
    logic [XLEN-1:0] cells [DEPTH];

    // Entry 0 is never written; it stays at its reset value of zero.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
        end else if (wr_en && (wr_idx != '0)) begin
            cells[wr_idx] <= wr_data;
        end
    end

    assign rd_a_data = (rd_a_idx == '0) ? '0 : cells[rd_a_idx];
    assign rd_b_data = (rd_b_idx == '0) ? '0 : cells[rd_b_idx];
endmodule

// File: rtl/rsx_alu.sv
module rsx_alu
    import rsx_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  alu_op_e         op,
    input  logic [XLEN-1:0] opnd_a,
    input  logic [XLEN-1:0] opnd_b,
    output logic [XLEN-1:0] result
);
    logic less;

    assign less = $signed(opnd_a) < $signed(opnd_b);

    always_comb begin
        unique case (op)
            ALU_ADD: result = opnd_a + opnd_b;
            ALU_SUB: result = opnd_a - opnd_b;
            ALU_SLT: result = {{(XLEN-1){1'b0}}, less};
            ALU_LUI: result = {opnd_b[IMM_W-1:0], {(XLEN-IMM_W){1'b0}}};
            default: result = '0;
        endcase
    end
endmodule

// File: rtl/rsx_exec_unit.sv
module rsx_exec_unit
    import rsx_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 instr_valid,
    input  logic [INSN_W-1:0]    instr_word,
    output logic                 wb_en,
    output logic [REG_IDX_W-1:0] wb_idx,
    output logic [XLEN-1:0]      wb_data,
    output logic                 illegal
);
    localparam int NREG = 2 ** REG_IDX_W;

    decoded_t        dec;
    logic [XLEN-1:0] val_a, val_b, opnd_b, imm_sx, alu_out;
    logic            commit;
    exec_state_e     state, state_nx;

    rsx_decoder u_dec (
        .instr_word (instr_word),
        .dec        (dec)
    );

    rsx_regfile #(.XLEN(XLEN), .DEPTH(NREG)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_a_idx  (dec.src_a),
        .rd_a_data (val_a),
        .rd_b_idx  (dec.src_b),
        .rd_b_data (val_b),
        .wr_en     (commit),
        .wr_idx    (dec.dst),
        .wr_data   (alu_out)
    );

    assign imm_sx = {{(XLEN-IMM_W){dec.imm[IMM_W-1]}}, dec.imm};
    assign opnd_b = dec.use_imm ? imm_sx : val_b;

    rsx_alu #(.XLEN(XLEN)) u_alu (
        .op     (dec.op),
        .opnd_a (val_a),
        .opnd_b (opnd_b),
        .result (alu_out)
    );

    assign commit = instr_valid && dec.legal && (dec.dst != '0);

    always_comb begin
        if (!instr_valid)        state_nx = S_IDLE;
        else if (!dec.legal)     state_nx = S_TRAP;
        else if (dec.dst == '0)  state_nx = S_SKIP;
        else                     state_nx = S_WRITE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            wb_idx  <= '0;
            wb_data <= '0;
        end else begin
            state <= state_nx;
            if (commit) begin
                wb_idx  <= dec.dst;
                wb_data <= alu_out;
            end
        end
    end

    always_comb begin
        unique case (state)
            S_IDLE:  begin wb_en = 1'b0; illegal = 1'b0; end
            S_WRITE: begin wb_en = 1'b1; illegal = 1'b0; end
            S_SKIP:  begin wb_en = 1'b0; illegal = 1'b0; end
            S_TRAP:  begin wb_en = 1'b0; illegal = 1'b1; end
            default: begin wb_en = 1'b0; illegal = 1'b0; end
        endcase
    end
endmodule

// File: rtl/rsx_exec_checker.sv
module rsx_exec_checker #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            instr_valid,
    input logic [31:0]     instr_word,
    input logic            wb_en,
    input logic [4:0]      wb_idx,
    input logic [XLEN-1:0] wb_data,
    input logic            illegal
);
    logic [5:0] opc;
    logic [5:0] fn;
    logic       known_opc;

    assign opc       = instr_word[31:26];
    assign fn        = instr_word[5:0];
    assign known_opc = (opc == 6'd0) || (opc == 6'd8) || (opc == 6'd10) || (opc == 6'd15);

    AST_WB_XOR_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(wb_en && illegal)); // R9

    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> (!wb_en && !illegal)); // R10

    AST_NO_R0_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (wb_idx != 5'd0)); // R8

    AST_BAD_OPC_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !known_opc) |=> (illegal && !wb_en)); // R9

    AST_LUI_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && opc == 6'd15 && instr_word[20:16] != 5'd0) |=>
        (wb_en && wb_data[15:0] == 16'd0 && wb_data[31:16] == $past(instr_word[15:0]))); // R7

    AST_SLT_BOOL: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && opc == 6'd0 && fn == 6'd42 && instr_word[15:11] != 5'd0) |=>
        (wb_en && wb_data[XLEN-1:1] == '0)); // R4

    AST_SLTI_BOOL: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && opc == 6'd10 && instr_word[20:16] != 5'd0) |=>
        (wb_en && wb_data[XLEN-1:1] == '0)); // R6

    AST_ZERO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && opc == 6'd0 && fn == 6'd32 && instr_word[25:21] == 5'd0 &&
         instr_word[20:16] == 5'd0 && instr_word[15:11] != 5'd0) |=>
        (wb_en && wb_data == '0)); // R8
endmodule

bind rsx_exec_unit rsx_exec_checker #(.XLEN(XLEN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr_word  (instr_word),
    .wb_en       (wb_en),
    .wb_idx      (wb_idx),
    .wb_data     (wb_data),
    .illegal     (illegal)
);

// File: tb/sim_rsx_exec_unit.sv
`timescale 1ns/1ps
module sim_rsx_exec_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr_word = '0;
    logic        wb_en, illegal;
    logic [4:0]  wb_idx;
    logic [31:0] wb_data;

    int checks = 0;
    int fails  = 0;
    logic [31:0] model [32];

    always #2 clk = ~clk;

    rsx_exec_unit u0 (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data), .illegal(illegal)
    );

    function automatic logic [31:0] rtype(input logic [5:0] fn, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [4:0] rd);
        return {6'd0, rs, rt, rd, 5'd0, fn};
    endfunction

    function automatic logic [31:0] itype(input logic [5:0] op, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic predict(input logic [31:0] w, output logic en, output logic [4:0] idx,
                           output logic [31:0] data, output logic ill);
        logic [5:0]  op = w[31:26];
        logic [31:0] a  = model[w[25:21]];
        logic [31:0] b  = model[w[20:16]];
        logic [31:0] sx = {{16{w[15]}}, w[15:0]};
        logic        ok = 1'b1;
        logic [4:0]  d  = w[20:16];
        data = '0;
        case (op)
            6'd0: begin
                d = w[15:11];
                case (w[5:0])
                    6'd32: data = a + b;
                    6'd34: data = a - b;
                    6'd42: data = {31'd0, $signed(a) < $signed(b)};
                    default: ok = 1'b0;
                endcase
            end
            6'd8:  data = a + sx;
            6'd10: data = {31'd0, $signed(a) < $signed(sx)};
            6'd15: data = {w[15:0], 16'd0};
            default: ok = 1'b0;
        endcase
        ill = !ok;
        en  = ok && (d != 5'd0);
        idx = d;
    endtask

    task automatic expect_out(input logic [31:0] w, input string tag);
        logic en, ill;
        logic [4:0] idx;
        logic [31:0] data;
        predict(w, en, idx, data, ill);
        chk(wb_en == en, {tag, " wb_en"}, {31'd0, wb_en}, {31'd0, en});
        chk(illegal == ill, {tag, " illegal"}, {31'd0, illegal}, {31'd0, ill});
        if (en) begin
            chk(wb_idx == idx, {tag, " wb_idx"}, {27'd0, wb_idx}, {27'd0, idx});
            chk(wb_data == data, {tag, " wb_data"}, wb_data, data);
            model[idx] = data;
        end
    endtask

    task automatic check_quiet();
        chk(!wb_en && !illegal, "R10 quiet after idle", {30'd0, wb_en, illegal}, 32'd0);
    endtask

    task automatic exec(input logic [31:0] w, input string tag);
        @(negedge clk);
        check_quiet();
        instr_valid = 1'b1;
        instr_word  = w;
        @(negedge clk);
        instr_valid = 1'b0;
        expect_out(w, tag);
    endtask

    task automatic exec_pair(input logic [31:0] w1, input logic [31:0] w2, input string tag);
        @(negedge clk);
        instr_valid = 1'b1;
        instr_word  = w1;
        @(negedge clk);
        instr_word  = w2;
        expect_out(w1, tag);
        @(negedge clk);
        instr_valid = 1'b0;
        expect_out(w2, tag);
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        checks++;
        $display("FAIL R10 watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) model[i] = '0;
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        chk(!wb_en && !illegal, "R1 outputs after reset", {30'd0, wb_en, illegal}, 32'd0);
        rst_n = 1'b1;
        for (int k = 0; k < 32; k++) exec(rtype(6'd32, k[4:0], 5'd0, 5'd1), "R1 entry reads zero");

        exec(itype(6'd8, 5'd0, 5'd17, 16'd1000), "R5 addi positive");
        exec(itype(6'd8, 5'd0, 5'd8, 16'hFFFD), "R5 addi negative immediate");
        exec(32'h02288020, "R2 add encoding");
        exec(itype(6'd8, 5'd0, 5'd9, 16'd5), "R5 addi setup");
        exec(32'h01309822, "R3 sub encoding");

        exec(itype(6'd15, 5'd0, 5'd2, 16'h8000), "R7 lui sign half");
        exec(rtype(6'd32, 5'd2, 5'd2, 5'd4), "R2 add wraps to zero");
        exec(itype(6'd8, 5'd0, 5'd3, 16'd1), "R5 addi one");
        exec(rtype(6'd34, 5'd0, 5'd3, 5'd5), "R3 sub wraps to all ones");
        exec(rtype(6'd42, 5'd5, 5'd3, 5'd6), "R4 slt -1 < 1");
        exec(rtype(6'd42, 5'd3, 5'd5, 5'd6), "R4 slt 1 < -1 false");
        exec(rtype(6'd42, 5'd3, 5'd3, 5'd6), "R4 slt equal false");
        exec(rtype(6'd42, 5'd2, 5'd3, 5'd6), "R4 slt most negative");
        exec(itype(6'd10, 5'd5, 5'd7, 16'd0), "R6 slti -1 < 0");
        exec(itype(6'd10, 5'd3, 5'd7, 16'hFFFF), "R6 slti 1 < -1 false");
        exec(itype(6'd10, 5'd0, 5'd7, 16'd1), "R6 slti 0 < 1");
        exec(itype(6'd15, 5'd3, 5'd10, 16'hABCD), "R7 lui low half zero");
        exec(itype(6'd8, 5'd10, 5'd10, 16'h1234), "R5 addi on lui value");

        exec(itype(6'd8, 5'd3, 5'd0, 16'd55), "R8 write to entry 0 dropped");
        exec(rtype(6'd32, 5'd0, 5'd0, 5'd11), "R8 entry 0 still zero");
        exec(rtype(6'd32, 5'd3, 5'd3, 5'd0), "R8 rtype to entry 0 dropped");

        exec(itype(6'd35, 5'd0, 5'd3, 16'h1234), "R9 unsupported opcode");
        exec(rtype(6'd32, 5'd3, 5'd0, 5'd12), "R9 target unchanged");
        exec(rtype(6'd33, 5'd5, 5'd5, 5'd3), "R9 unsupported funct");
        exec(rtype(6'd32, 5'd3, 5'd0, 5'd12), "R9 rd unchanged");

        exec_pair(itype(6'd8, 5'd0, 5'd13, 16'd77), rtype(6'd32, 5'd13, 5'd13, 5'd14), "R10 back to back");
        exec_pair(itype(6'd15, 5'd0, 5'd13, 16'h00FF), itype(6'd10, 5'd13, 5'd15, 16'h7FFF), "R10 back to back slti");

        for (int n = 0; n < 600; n++) begin
            logic [31:0] w;
            logic [4:0]  rs = 5'($urandom_range(0, 7));
            logic [4:0]  rt = 5'($urandom_range(0, 7));
            logic [4:0]  rd = 5'($urandom_range(0, 7));
            logic [15:0] imm = 16'($urandom);
            case ($urandom_range(0, 7))
                0: w = rtype(6'd32, rs, rt, rd);
                1: w = rtype(6'd34, rs, rt, rd);
                2: w = rtype(6'd42, rs, rt, rd);
                3: w = itype(6'd8, rs, rt, imm);
                4: w = itype(6'd10, rs, rt, imm);
                5: w = itype(6'd15, rs, rt, imm);
                6: w = rtype(6'($urandom), rs, rt, rd);
                default: w = $urandom;
            endcase
            exec(w, "R2 R3 R4 R5 R6 R7 R8 R9 random");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule